// File: doc/BRIEF.md
# Page Frame Replacement Tracker

This block follows which virtual pages sit in a small, fixed pool of physical page frames. Each frame holds one page number, and the frames are kept as one ordered list that runs from the oldest entry to the newest. A one-bit policy setting chooses between least-recently-used and first-in-first-out replacement. Both policies use the same list. The only difference is on a hit: least-recently-used moves the touched page to the newest end, while first-in-first-out leaves the list alone.

Each access strobe carries a page number. The block handles one access per cycle. One cycle later it gives a registered result: hit or miss, and on a miss the page that was pushed out. On a miss the page at the oldest end is dropped and the new page goes in at the newest end. The full resident list is always visible on an output bus. Two saturating counters count hits and misses.

Top module: `page_frame_tracker`

## Requirements
- R1: After reset the four frames hold pages 1, 2, 3, 4 from oldest (slot 0, bits [7:0] of `resident_o`) to newest (slot 3, bits [31:24]). Both counters read 0 and `res_valid_o` is low.
- R2: An access presented with `acc_valid_i` high at a clock edge gives `res_valid_o` high during the following cycle. In a cycle with no strobe, `res_valid_o` is low, the resident list does not change and the counters do not change.
- R3: A result reports `hit_o` high when the accessed page is in one of the frames and `miss_o` high otherwise. Exactly one of the two is high while `res_valid_o` is high, and both are low otherwise.
- R4: On a miss, `evict_page_o` carries the page that was in the oldest slot. On a hit, and when there is no result, it reads 0.
- R5: On a miss under either policy, slots 1 to 3 move down by one slot and the new page goes into slot 3.
- R6: With least-recently-used selected (policy value 0), a hit on slot k moves that page to slot 3 and moves each page in slots above k down by one slot. Starting from reset, the accesses 6, 3, 2, 8, 4 leave 3, 2, 8, 4.
- R7: With first-in-first-out selected (policy value 1), a hit leaves the list unchanged. Starting from reset, the accesses 6, 3, 2, 8, 4 leave 3, 4, 6, 8.
- R8: `policy_i` is taken only at clock edges where `acc_valid_i` is low. The policy in force after reset is least-recently-used. A change made while strobes are back to back has no effect until an idle edge.
- R9: Each access adds exactly one to the hit counter or to the miss counter, in the same cycle that its result is shown.
- R10: Each counter stops at its all-ones value and stays there.
- R11: A cyclic pattern over five distinct pages misses on every access once the first round has passed, under both policies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 1 | Replacement policy: 0 least-recently-used, 1 first-in-first-out |
| acc_valid_i | input | 1 | Access strobe |
| acc_page_i | input | PAGE_W | Page number of the access |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| hit_o | output | 1 | The access found its page resident |
| miss_o | output | 1 | The access did not find its page |
| evict_page_o | output | PAGE_W | Page dropped on a miss, 0 otherwise |
| resident_o | output | FRAMES*PAGE_W | Resident pages, slot 0 (oldest) in the low bits |
| hit_count_o | output | CNT_W | Saturating hit counter |
| miss_count_o | output | CNT_W | Saturating miss counter |

## Verification
The fixed sequence 6, 3, 2, 8, 4 is run under each policy from reset. It separates the two policies, because their final lists differ only through how hits on pages 3 and 2 were handled. A five-page cyclic pattern shows that the shared eviction path gives back-to-back misses under both policies. Held strobes with a policy change in the middle show whether the policy is taken too early. A pair sweep over pages 0 to 5 under both policies, with idle cycles in between, hits every slot position and every miss case, and it drives a narrow counter into saturation.

// File: rtl/pft_pkg.sv
package pft_pkg;

  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_FIFO = 1'b1
  } repl_policy_e;

endpackage

// File: rtl/pft_match.sv
module pft_match #(
  parameter int FRAMES = 4,
  parameter int PAGE_W = 8,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic [FRAMES-1:0][PAGE_W-1:0] slots_i,
  input  logic [PAGE_W-1:0]             page_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);

  logic [FRAMES-1:0] eq;

  for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
    assign eq[g] = (slots_i[g] == page_i);
  end

  always_comb begin
    idx_o = '0;
    for (int k = FRAMES - 1; k >= 0; k--) begin
      if (eq[k]) idx_o = IDX_W'(k);
    end
  end

  assign hit_o = |eq;

endmodule

// File: rtl/pft_order.sv
module pft_order #(
  parameter int FRAMES = 4,
  parameter int PAGE_W = 8,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_i,
  input  logic [IDX_W-1:0]              from_i,
  input  logic [PAGE_W-1:0]             page_i,
  output logic [FRAMES-1:0][PAGE_W-1:0] slots_o
);

  for (genvar g = 0; g < FRAMES; g++) begin : g_slot
    logic [PAGE_W-1:0] nxt;
    if (g == FRAMES - 1) begin : g_top
      assign nxt = page_i;
    end else begin : g_mid
      assign nxt = (g >= int'(from_i)) ? slots_o[g+1] : slots_o[g];
    end

    always_ff @(posedge clk) begin
      if (rst) slots_o[g] <= PAGE_W'(g + 1);
      else if (upd_i) slots_o[g] <= nxt;
    end
  end

  AST_NEWEST_LOADED: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> slots_o[FRAMES-1] == $past(page_i)); // R5
  AST_LIST_HELD: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(slots_o)); // R2

endmodule

// File: rtl/pft_sat_counter.sv
module pft_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_o) == TOP |-> cnt_o == TOP); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(cnt_o)); // R9

endmodule

// File: rtl/page_frame_tracker.sv
module page_frame_tracker #(
  parameter int FRAMES = 4,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       policy_i,
  input  logic                       acc_valid_i,
  input  logic [PAGE_W-1:0]          acc_page_i,
  output logic                       res_valid_o,
  output logic                       hit_o,
  output logic                       miss_o,
  output logic [PAGE_W-1:0]          evict_page_o,
  output logic [FRAMES*PAGE_W-1:0]   resident_o,
  output logic [CNT_W-1:0]           hit_count_o,
  output logic [CNT_W-1:0]           miss_count_o
);
  import pft_pkg::*;

  repl_policy_e                  pol_q;
  logic [FRAMES-1:0][PAGE_W-1:0] slots;
  logic                          found;
  logic [IDX_W-1:0]              found_idx;
  logic                          upd;
  logic [IDX_W-1:0]              from_idx;

  always_ff @(posedge clk) begin
    if (rst) pol_q <= POL_LRU;
    else if (!acc_valid_i) pol_q <= repl_policy_e'(policy_i);
  end

  pft_match #(.FRAMES(FRAMES), .PAGE_W(PAGE_W)) u_match (
    .slots_i (slots),
    .page_i  (acc_page_i),
    .hit_o   (found),
    .idx_o   (found_idx)
  );

  assign upd      = acc_valid_i && (!found || pol_q == POL_LRU);
  assign from_idx = found ? found_idx : '0;

  pft_order #(.FRAMES(FRAMES), .PAGE_W(PAGE_W)) u_order (
    .clk     (clk),
    .rst     (rst),
    .upd_i   (upd),
    .from_i  (from_idx),
    .page_i  (acc_page_i),
    .slots_o (slots)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      evict_page_o <= '0;
    end else begin
      res_valid_o  <= acc_valid_i;
      hit_o        <= acc_valid_i && found;
      miss_o       <= acc_valid_i && !found;
      evict_page_o <= (acc_valid_i && !found) ? slots[0] : '0;
    end
  end

  pft_sat_counter #(.CNT_W(CNT_W)) u_hit_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (acc_valid_i && found),
    .cnt_o (hit_count_o)
  );

  pft_sat_counter #(.CNT_W(CNT_W)) u_miss_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (acc_valid_i && !found),
    .cnt_o (miss_count_o)
  );

  for (genvar g = 0; g < FRAMES; g++) begin : g_flat
    assign resident_o[g*PAGE_W +: PAGE_W] = slots[g];
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i |=> res_valid_o); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $onehot({hit_o, miss_o})); // R3
  AST_NO_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !res_valid_o |-> !hit_o && !miss_o); // R3
  AST_EVICT_OLDEST: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && !found |=> evict_page_o == $past(slots[0])); // R4
  AST_LRU_TO_NEWEST: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && found && pol_q == POL_LRU |=> slots[FRAMES-1] == $past(acc_page_i)); // R6
  AST_FIFO_HIT_KEEP: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && found && pol_q == POL_FIFO |=> $stable(slots)); // R7
  AST_POLICY_HOLD: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i |=> $stable(pol_q)); // R8

endmodule

// File: tb/test_page_frame_tracker.sv
`timescale 1ns/1ps
module test_page_frame_tracker;

  localparam int FRAMES = 4;
  localparam int PAGE_W = 8;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     pol_in = 1'b0;
  logic                     acc_v = 1'b0;
  logic [PAGE_W-1:0]        acc_pg = '0;
  logic                     res_valid, hit, miss;
  logic [PAGE_W-1:0]        evict;
  logic [FRAMES*PAGE_W-1:0] resident;
  logic [CNT_W-1:0]         hcnt, mcnt;

  int checks = 0;
  int errors = 0;

  int m[FRAMES];
  int mpol, mhc, mmc;
  int steady_hits;

  always #2.5 clk = ~clk;

  page_frame_tracker #(.FRAMES(FRAMES), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) i_page_frame_tracker (
    .clk          (clk),
    .rst          (rst),
    .policy_i     (pol_in),
    .acc_valid_i  (acc_v),
    .acc_page_i   (acc_pg),
    .res_valid_o  (res_valid),
    .hit_o        (hit),
    .miss_o       (miss),
    .evict_page_o (evict),
    .resident_o   (resident),
    .hit_count_o  (hcnt),
    .miss_count_o (mcnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slot(input int k);
    return int'(resident[k*PAGE_W +: PAGE_W]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    acc_v = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < FRAMES; k++) m[k] = k + 1;
    mpol = 0; mhc = 0; mmc = 0;
    @(negedge clk);
    mpol = int'(pol_in);
    for (int k = 0; k < FRAMES; k++) chk(slot(k) == k + 1, "R1 reset slot", slot(k), k + 1);
    chk(hcnt == 0 && mcnt == 0, "R1 reset counters", int'(hcnt) + int'(mcnt), 0);
    chk(res_valid == 1'b0, "R1 reset result", int'(res_valid), 0);
  endtask

  task automatic step(input bit v, input int pg);
    int found, exp_ev;
    bit exp_hit;
    string tag;
    acc_v  = v;
    acc_pg = PAGE_W'(pg);
    @(negedge clk);
    exp_hit = 1'b0;
    exp_ev = 0;
    tag = "R2 idle list";
    if (v) begin
      found = -1;
      for (int k = FRAMES - 1; k >= 0; k--) if (m[k] == pg) found = k;
      if (found < 0) begin
        exp_ev = m[0];
        for (int k = 0; k < FRAMES - 1; k++) m[k] = m[k+1];
        m[FRAMES-1] = pg;
        if (mmc < CMAX) mmc++;
        tag = "R5 miss list";
      end else begin
        exp_hit = 1'b1;
        if (mpol == 0) begin
          for (int k = found; k < FRAMES - 1; k++) m[k] = m[k+1];
          m[FRAMES-1] = pg;
          tag = "R6 lru hit list";
        end else begin
          tag = "R7 fifo hit list";
        end
        if (mhc < CMAX) mhc++;
      end
    end else begin
      mpol = int'(pol_in);
    end
    chk(res_valid == v, "R2 result valid", int'(res_valid), int'(v));
    chk(hit == (v && exp_hit), "R3 hit flag", int'(hit), int'(v && exp_hit));
    chk(miss == (v && !exp_hit), "R3 miss flag", int'(miss), int'(v && !exp_hit));
    chk(int'(evict) == exp_ev, "R4 evicted page", int'(evict), exp_ev);
    for (int k = 0; k < FRAMES; k++) chk(slot(k) == m[k], tag, slot(k), m[k]);
    chk(int'(hcnt) == mhc, "R9 hit counter", int'(hcnt), mhc);
    chk(int'(mcnt) == mmc, "R9 miss counter", int'(mcnt), mmc);
  endtask

  task automatic run_example();
    step(1, 6); step(1, 3); step(1, 2); step(1, 8); step(1, 4); step(0, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 and R6 worked example
    pol_in = 1'b0;
    do_reset();
    step(0, 0);
    run_example();
    chk(slot(0) == 3 && slot(1) == 2 && slot(2) == 8 && slot(3) == 4,
        "R6 example final", slot(0) * 1000 + slot(1) * 100 + slot(2) * 10 + slot(3), 3284);

    // R7 worked example
    pol_in = 1'b1;
    do_reset();
    step(0, 0);
    run_example();
    chk(slot(0) == 3 && slot(1) == 4 && slot(2) == 6 && slot(3) == 8,
        "R7 example final", slot(0) * 1000 + slot(1) * 100 + slot(2) * 10 + slot(3), 3468);

    // R11 cyclic five-page pattern
    for (int p = 0; p < 2; p++) begin
      pol_in = p[0];
      do_reset();
      step(0, 0);
      for (int pg = 1; pg <= 5; pg++) step(1, pg);
      steady_hits = 0;
      for (int r = 0; r < 2; r++) begin
        for (int pg = 1; pg <= 5; pg++) begin
          step(1, pg);
          if (hit) steady_hits++;
        end
      end
      step(0, 0);
      chk(steady_hits == 0, "R11 cyclic steady hits", steady_hits, 0);
    end

    // R8 policy taken only on idle edges
    pol_in = 1'b0;
    do_reset();
    step(0, 0);
    pol_in = 1'b1;
    step(1, 1);
    step(1, 2);
    chk(slot(3) == 2 && slot(2) == 1, "R8 held strobe keeps LRU", slot(3) * 10 + slot(2), 21);
    step(0, 0);
    step(1, 3);
    chk(slot(0) == 3 && slot(3) == 2, "R8 FIFO after idle", slot(0) * 10 + slot(3), 32);
    step(0, 0);

    // Pair sweep under both policies; R10 saturation
    for (int p = 0; p < 2; p++) begin
      pol_in = p[0];
      do_reset();
      step(0, 0);
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          step(1, a);
          step(1, b);
          if (((a + b) % 3) == 0) step(0, 0);
        end
      end
      step(0, 0);
      chk(int'(hcnt) == CMAX, "R10 hit counter saturated", int'(hcnt), CMAX);
      chk(int'(mcnt) == CMAX, "R10 miss counter saturated", int'(mcnt), CMAX);
    end

    finish_run();
  end

endmodule